// File: doc/BRIEF.md
# Queue-to-Queue Packet Mover

This block is a small packet-DMA engine. It sits between a queue manager and a word-wide buffer memory. It watches one transmit queue. When that queue holds a descriptor, the engine pops it and reads the packet length, the receive-flow number, the source buffer pointer and the return-queue number from it. It then pops an empty descriptor from the free queue that the selected receive flow names, and copies the payload word by word into that descriptor's buffer. Finally it pushes the transmit descriptor to its return queue and the filled receive descriptor to the flow's destination queue.

Each receive flow has its own starvation mode, which decides what happens when its free queue is empty. In drop mode the packet is discarded and the transmit descriptor is returned at once. In hold mode the engine keeps the transmit descriptor and tries the free queue again once a programmable number of cycles has passed. A running count of empty free-queue pops can be read out. The engine handles one packet at a time, and a busy output covers the whole of each transfer.

Descriptor layout (byte offsets from the descriptor base): +0 is the info word, with the length in words in [15:0], the flow number in [17:16] and the truncation flag in bit 31. +4 is the buffer pointer. +8 is the buffer capacity in words, in [15:0]. +12 is the return queue number, in its low bits. A pointer on the queue port carries a size hint in its low 4 bits. A popped value of 0 means the queue was empty.

Top module: `q2q_mover`

## Requirements
- R1: While rst_n is low at a clock edge, busy is 0, starve_cnt is 0 and mem_req is 0 in the next cycle.
- R2: While the transmit queue count is 0 the engine issues only count requests (qm_op 0) on tx_qnum and no pops or memory accesses. A pop (qm_op 1) of tx_qnum precedes every free-queue pop.
- R3: The free queue popped is cfg_free_q of the flow given by bits [17:16] of the transmit info word.
- R4: The engine copies min(length, capacity) words from the transmit buffer into the receive buffer in order, and writes no word beyond that count.
- R5: The engine writes the receive info word as {trunc, 15'b0, copied words}. Trunc is 1 exactly when the length exceeds the capacity.
- R6: On completion the engine pushes (qm_op 2, appended at the tail) the original transmit pointer, with its hint bits, to the return queue. It then pushes the original receive pointer to cfg_dest_q of the flow. The queue port holds a request stable until qm_ack.
- R7: The engine clears the low 4 bits of a descriptor pointer before using it as a memory address. All memory addresses are word aligned.
- R8: An empty free-queue pop on a flow whose cfg_hold bit is 0 drops the packet. The transmit descriptor is pushed to its return queue, no receive push follows and no memory write occurs.
- R9: An empty free-queue pop on a flow whose cfg_hold bit is 1 holds the transmit descriptor. The free queue is popped again cfg_timeout+2 cycles later, and the transfer completes once a descriptor is available.
- R10: starve_cnt rises by exactly 1 for each empty free-queue pop and changes at no other time.
- R11: busy is 1 from the cycle after the transmit pop is accepted through the cycle in which the last push is accepted, and 0 in the cycle after that. The engine never pops the transmit queue while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_qnum | input | QW | Transmit queue that is watched |
| cfg_free_q | input | NF*QW | Free-queue number per flow |
| cfg_dest_q | input | NF*QW | Destination queue number per flow |
| cfg_hold | input | NF | Starvation mode per flow (1 = hold and retry) |
| cfg_timeout | input | TW | Retry delay in cycles |
| qm_req | output | 1 | Queue request valid |
| qm_op | output | 2 | 0 count, 1 pop, 2 tail push |
| qm_qnum | output | QW | Queue addressed |
| qm_wdata | output | 32 | Pointer to push |
| qm_ack | input | 1 | Queue request accepted |
| qm_rdata | input | 32 | Count or popped pointer (0 = empty) |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Memory write |
| mem_addr | output | 32 | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Memory request accepted |
| mem_rdata | input | 32 | Read data |
| busy | output | 1 | Transfer in progress |
| starve_cnt | output | 16 | Count of empty free-queue pops |

## Verification
The bench runs the transfer path with several kinds of packet: a short packet into a roomy buffer, a packet longer than its buffer, a packet that exactly fills its buffer, and two packets queued back to back. These separate a correct length clip and truncation flag from an off-by-one copy, and show that the first packet's return and delivery happen before the second packet's pop. A flow in drop mode and a flow in hold mode are then each starved. The drop case shows that the return happens without any memory write. The hold case measures the spacing between retries and matches the starvation count to the empty pops observed. Pointers carry nonzero hint bits throughout, so a missing mask shows up as wrong addresses.

// File: rtl/q2q_pkg.sv
// Shared encodings for the queue-to-queue packet mover.
// Assumes 32-bit words and 32-bit descriptor pointers.
package q2q_pkg;
    localparam int DW = 32;
    localparam int HINT_BITS = 4;
    localparam int LEN_W = 16;
    localparam int FLOW_LSB = 16;
    localparam int TRUNC_BIT = 31;

    // Byte offsets of descriptor words.
    localparam logic [DW-1:0] OFS_INFO = 32'd0;
    localparam logic [DW-1:0] OFS_BUF  = 32'd4;
    localparam logic [DW-1:0] OFS_CAP  = 32'd8;
    localparam logic [DW-1:0] OFS_RETQ = 32'd12;

    typedef enum logic [1:0] {
        QOP_COUNT = 2'd0,
        QOP_POP   = 2'd1,
        QOP_PUSH  = 2'd2
    } qop_e;

    typedef enum logic [3:0] {
        S_IDLE, S_POP_TX, S_RD_TXI, S_RD_TXB, S_RD_TXR, S_POP_FREE, S_WAIT,
        S_RD_RXB, S_RD_RXC, S_COPY_RD, S_COPY_WR, S_WR_RXI, S_RET_TX, S_PUSH_RX
    } st_e;
endpackage

// File: rtl/q2q_flow_sel.sv
// Selects one receive flow's settings from the flattened per-flow vectors.
// Assumes NF >= 2 and a flow id that is always below NF.
module q2q_flow_sel #(
    parameter int NF = 4,
    parameter int QW = 6,
    localparam int FW = $clog2(NF)
) (
    input  logic [FW-1:0]    flow_id,
    input  logic [NF*QW-1:0] cfg_free_q,
    input  logic [NF*QW-1:0] cfg_dest_q,
    input  logic [NF-1:0]    cfg_hold,
    output logic [QW-1:0]    free_q,
    output logic [QW-1:0]    dest_q,
    output logic             hold
);
    logic [QW-1:0] free_arr [NF];
    logic [QW-1:0] dest_arr [NF];

    // Unpack the per-flow fields into arrays.
    for (genvar g = 0; g < NF; g++) begin : g_unpack
        assign free_arr[g] = cfg_free_q[g*QW +: QW];
        assign dest_arr[g] = cfg_dest_q[g*QW +: QW];
    end

    // Pick the active flow.
    always_comb begin
        free_q = free_arr[flow_id];
        dest_q = dest_arr[flow_id];
        hold   = cfg_hold[flow_id];
    end
endmodule

// File: rtl/q2q_len_clip.sv
// Clips the requested copy length to the receive buffer capacity and flags truncation.
// Purely combinational; the clock and reset only time its assertion.
module q2q_len_clip #(
    parameter int LW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [LW-1:0] want,
    input  logic [LW-1:0] room,
    output logic [LW-1:0] n,
    output logic          trunc
);
    // Take the smaller of the two lengths.
    always_comb begin
        trunc = (want > room);
        n     = trunc ? room : want;
    end

    // R5: the clipped count never exceeds either input, and it equals the request when there is no truncation.
    p_clip_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (n <= room) && (n <= want) && (trunc || (n == want)));
endmodule

// File: rtl/q2q_retry_timer.sv
// Counts a programmable delay after a start pulse and then raises expired for one cycle.
// Assumes start is not pulsed again while a count is running.
module q2q_retry_timer #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [TW-1:0] limit,
    output logic          expired
);
    logic [TW-1:0] cnt;
    logic          run;

    // Load on start, count down while running, stop at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            run <= 1'b0;
        end else if (start) begin
            cnt <= limit;
            run <= 1'b1;
        end else if (run && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end else if (run) begin
            run <= 1'b0;
        end
    end

    assign expired = run && (cnt == '0);

    // R9: a nonzero limit never expires in the cycle after start.
    p_no_early_expiry_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (start && limit != '0) |=> !expired);
    // R9: expiry lasts a single cycle.
    p_single_expiry_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (expired && !start) |=> !expired);
endmodule

// File: rtl/q2q_mover.sv
// Queue-to-queue packet mover: pops a transmit descriptor, takes a free receive
// descriptor for the flow named by it, copies the payload, returns and delivers.
// Assumes a queue port that answers pops with 0 when empty, a memory port
// that may stall, and flow settings that stay stable during a transfer.
module q2q_mover
    import q2q_pkg::*;
#(
    parameter int NF = 4,
    parameter int QW = 6,
    parameter int TW = 16,
    localparam int FW = $clog2(NF)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [QW-1:0]    tx_qnum,
    input  logic [NF*QW-1:0] cfg_free_q,
    input  logic [NF*QW-1:0] cfg_dest_q,
    input  logic [NF-1:0]    cfg_hold,
    input  logic [TW-1:0]    cfg_timeout,
    output logic             qm_req,
    output logic [1:0]       qm_op,
    output logic [QW-1:0]    qm_qnum,
    output logic [31:0]      qm_wdata,
    input  logic             qm_ack,
    input  logic [31:0]      qm_rdata,
    output logic             mem_req,
    output logic             mem_we,
    output logic [31:0]      mem_addr,
    output logic [31:0]      mem_wdata,
    input  logic             mem_ack,
    input  logic [31:0]      mem_rdata,
    output logic             busy,
    output logic [15:0]      starve_cnt
);
    st_e              state;
    logic [DW-1:0]    txd_raw, rxd_raw, src_buf, dst_buf, data_r;
    logic [LEN_W-1:0] tx_len, copy_n, idx;
    logic [FW-1:0]    flow_id;
    logic [QW-1:0]    ret_q;
    logic             trunc_r;
    logic [QW-1:0]    free_q, dest_q;
    logic             hold;
    logic [LEN_W-1:0] clip_n;
    logic             clip_trunc;
    logic             tmr_start, tmr_expired;
    logic             free_empty;
    logic [DW-1:0]    txd_base, rxd_base;

    assign txd_base = {txd_raw[DW-1:HINT_BITS], {HINT_BITS{1'b0}}};
    assign rxd_base = {rxd_raw[DW-1:HINT_BITS], {HINT_BITS{1'b0}}};
    assign free_empty = (state == S_POP_FREE) && qm_ack && (qm_rdata == '0);
    assign tmr_start = free_empty && hold;

    q2q_flow_sel #(.NF(NF), .QW(QW)) u_flow (
        .flow_id(flow_id), .cfg_free_q(cfg_free_q), .cfg_dest_q(cfg_dest_q),
        .cfg_hold(cfg_hold), .free_q(free_q), .dest_q(dest_q), .hold(hold)
    );

    q2q_len_clip #(.LW(LEN_W)) u_clip (
        .clk(clk), .rst_n(rst_n), .want(tx_len), .room(mem_rdata[LEN_W-1:0]),
        .n(clip_n), .trunc(clip_trunc)
    );

    q2q_retry_timer #(.TW(TW)) u_timer (
        .clk(clk), .rst_n(rst_n), .start(tmr_start), .limit(cfg_timeout),
        .expired(tmr_expired)
    );

    // Queue port request for the current state.
    always_comb begin
        qm_req   = 1'b0;
        qm_op    = QOP_COUNT;
        qm_qnum  = tx_qnum;
        qm_wdata = '0;
        unique case (state)
            S_IDLE:     qm_req = 1'b1;
            S_POP_TX:   begin qm_req = 1'b1; qm_op = QOP_POP; end
            S_POP_FREE: begin qm_req = 1'b1; qm_op = QOP_POP; qm_qnum = free_q; end
            S_RET_TX:   begin qm_req = 1'b1; qm_op = QOP_PUSH; qm_qnum = ret_q; qm_wdata = txd_raw; end
            S_PUSH_RX:  begin qm_req = 1'b1; qm_op = QOP_PUSH; qm_qnum = dest_q; qm_wdata = rxd_raw; end
            default:    ;
        endcase
    end

    // Memory port request for the current state.
    always_comb begin
        mem_req   = 1'b1;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        unique case (state)
            S_RD_TXI:  mem_addr = txd_base + OFS_INFO;
            S_RD_TXB:  mem_addr = txd_base + OFS_BUF;
            S_RD_TXR:  mem_addr = txd_base + OFS_RETQ;
            S_RD_RXB:  mem_addr = rxd_base + OFS_BUF;
            S_RD_RXC:  mem_addr = rxd_base + OFS_CAP;
            S_COPY_RD: mem_addr = src_buf + (DW'(idx) << 2);
            S_COPY_WR: begin
                mem_we    = 1'b1;
                mem_addr  = dst_buf + (DW'(idx) << 2);
                mem_wdata = data_r;
            end
            S_WR_RXI: begin
                mem_we    = 1'b1;
                mem_addr  = rxd_base + OFS_INFO;
                mem_wdata = {trunc_r, {(DW-1-LEN_W){1'b0}}, copy_n};
            end
            default:   mem_req = 1'b0;
        endcase
    end

    assign busy = (state != S_IDLE) && (state != S_POP_TX);

    // Transfer sequencer: advances on each accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            txd_raw <= '0;
            rxd_raw <= '0;
            src_buf <= '0;
            dst_buf <= '0;
            data_r  <= '0;
            tx_len  <= '0;
            copy_n  <= '0;
            idx     <= '0;
            flow_id <= '0;
            ret_q   <= '0;
            trunc_r <= 1'b0;
        end else begin
            unique case (state)
                S_IDLE:   if (qm_ack && qm_rdata != '0) state <= S_POP_TX;
                S_POP_TX: if (qm_ack) begin
                    txd_raw <= qm_rdata;
                    state   <= (qm_rdata == '0) ? S_IDLE : S_RD_TXI;
                end
                S_RD_TXI: if (mem_ack) begin
                    tx_len  <= mem_rdata[LEN_W-1:0];
                    flow_id <= mem_rdata[FLOW_LSB +: FW];
                    state   <= S_RD_TXB;
                end
                S_RD_TXB: if (mem_ack) begin
                    src_buf <= mem_rdata;
                    state   <= S_RD_TXR;
                end
                S_RD_TXR: if (mem_ack) begin
                    ret_q <= mem_rdata[QW-1:0];
                    state <= S_POP_FREE;
                end
                S_POP_FREE: if (qm_ack) begin
                    rxd_raw <= qm_rdata;
                    if (qm_rdata != '0) state <= S_RD_RXB;
                    else if (hold)      state <= S_WAIT;
                    else                state <= S_RET_TX;
                end
                S_WAIT:   if (tmr_expired) state <= S_POP_FREE;
                S_RD_RXB: if (mem_ack) begin
                    dst_buf <= mem_rdata;
                    state   <= S_RD_RXC;
                end
                S_RD_RXC: if (mem_ack) begin
                    copy_n  <= clip_n;
                    trunc_r <= clip_trunc;
                    idx     <= '0;
                    state   <= (clip_n == '0) ? S_WR_RXI : S_COPY_RD;
                end
                S_COPY_RD: if (mem_ack) begin
                    data_r <= mem_rdata;
                    state  <= S_COPY_WR;
                end
                S_COPY_WR: if (mem_ack) begin
                    idx   <= idx + 1'b1;
                    state <= (idx + 1'b1 == copy_n) ? S_WR_RXI : S_COPY_RD;
                end
                S_WR_RXI: if (mem_ack) state <= S_RET_TX;
                S_RET_TX: if (qm_ack) state <= (rxd_raw == '0) ? S_IDLE : S_PUSH_RX;
                S_PUSH_RX: if (qm_ack) state <= S_IDLE;
                default:  state <= S_IDLE;
            endcase
        end
    end

    // Starvation event counter.
    always_ff @(posedge clk) begin
        if (!rst_n)          starve_cnt <= '0;
        else if (free_empty) starve_cnt <= starve_cnt + 1'b1;
    end

    // R1: reset leaves the block idle with a cleared counter.
    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> (!busy && starve_cnt == '0 && !mem_req));
    // R6: a queue request stays stable until accepted.
    p_qm_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (qm_req && !qm_ack) |=> (qm_req && $stable(qm_op) && $stable(qm_qnum) && $stable(qm_wdata)));
    // R7: every memory address is word aligned.
    p_word_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[1:0] == 2'b00));
    // R11: no transmit pop while a transfer is in flight.
    p_one_inflight_r11: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !(qm_req && qm_op == QOP_POP && qm_qnum == tx_qnum));
    // R8: an empty pop on a drop-mode flow is followed by a push and no memory use.
    p_drop_return_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (free_empty && !hold) |=> (qm_req && qm_op == QOP_PUSH && !mem_req));
    // R9: an empty pop on a hold-mode flow leaves the queue port quiet next cycle.
    p_hold_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (free_empty && hold) |=> !qm_req);
    // R10: the starvation counter only ever steps by one.
    p_starve_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (starve_cnt != $past(starve_cnt)) |-> (starve_cnt == $past(starve_cnt) + 16'd1));
endmodule

// File: tb/q2q_mover_test.sv
module q2q_mover_test;
    import q2q_pkg::*;
    localparam int CLK_PERIOD = 10;
    localparam int NF = 4;
    localparam int QW = 6;
    localparam int TW = 16;
    localparam int TXQ = 1;
    localparam int RETQ = 30;
    localparam int TMO = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [QW-1:0] tx_qnum = QW'(TXQ);
    logic [NF*QW-1:0] cfg_free_q, cfg_dest_q;
    logic [NF-1:0] cfg_hold = 4'b1000;
    logic [TW-1:0] cfg_timeout = TW'(TMO);
    logic qm_req, qm_ack = 1'b0;
    logic [1:0] qm_op;
    logic [QW-1:0] qm_qnum;
    logic [31:0] qm_wdata, qm_rdata = '0;
    logic mem_req, mem_we, mem_ack = 1'b0;
    logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
    logic busy;
    logic [15:0] starve_cnt;

    always #(CLK_PERIOD/2) clk = ~clk;

    q2q_mover #(.NF(NF), .QW(QW), .TW(TW)) uut (
        .clk(clk), .rst_n(rst_n), .tx_qnum(tx_qnum), .cfg_free_q(cfg_free_q),
        .cfg_dest_q(cfg_dest_q), .cfg_hold(cfg_hold), .cfg_timeout(cfg_timeout),
        .qm_req(qm_req), .qm_op(qm_op), .qm_qnum(qm_qnum), .qm_wdata(qm_wdata),
        .qm_ack(qm_ack), .qm_rdata(qm_rdata), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .busy(busy), .starve_cnt(starve_cnt)
    );

    // Flow f: free queue 10+f, destination queue 20+f.
    for (genvar f = 0; f < NF; f++) begin : g_cfg
        assign cfg_free_q[f*QW +: QW] = QW'(10 + f);
        assign cfg_dest_q[f*QW +: QW] = QW'(20 + f);
    end

    int checks = 0, failures = 0, cyc = 0;
    logic [31:0] mem_w [4096];
    logic [31:0] qs [64][$];
    logic [37:0] exp_push [$];      // {qnum, pointer}
    int exp_fq [$];
    int cur_fq = -1;
    bit tx_popped = 0, chk_busy_hi = 0, chk_busy_lo = 0;
    int txpop_cnt = 0, empty_pops = 0, mem_wr_cnt = 0, mem_acc_cnt = 0, last_empty = -1;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Queue manager and memory models; also the scoreboard monitor.
    always @(negedge clk) begin
        cyc++;
        if (chk_busy_hi) chk(busy === 1'b1, "R11 busy after tx pop", busy, 1);
        if (chk_busy_lo) chk(busy === 1'b0, "R11 busy after last push", busy, 0);
        chk_busy_hi = 0;
        chk_busy_lo = 0;
        qm_ack = qm_req;
        qm_rdata = '0;
        if (qm_req) begin
            if (qm_op == QOP_COUNT) qm_rdata = qs[qm_qnum].size();
            else if (qm_op == QOP_POP) begin
                if (qs[qm_qnum].size() > 0) qm_rdata = qs[qm_qnum].pop_front();
                if (int'(qm_qnum) == TXQ && qm_rdata != 0) begin
                    chk(!tx_popped, "R11 single transfer in flight", tx_popped, 0);
                    tx_popped = 1;
                    txpop_cnt++;
                    chk_busy_hi = 1;
                    cur_fq = (exp_fq.size() > 0) ? exp_fq.pop_front() : -1;
                end else if (int'(qm_qnum) != TXQ) begin
                    chk(tx_popped, "R2 tx pop precedes free pop", tx_popped, 1);
                    chk(int'(qm_qnum) == cur_fq, "R3 free queue of flow", qm_qnum, cur_fq);
                    if (qm_rdata == 0) begin
                        empty_pops++;
                        if (last_empty >= 0)
                            chk(cyc - last_empty == TMO + 2, "R9 retry spacing", cyc - last_empty, TMO + 2);
                        last_empty = cyc;
                    end
                end
            end else begin
                logic [37:0] e;
                e = (exp_push.size() > 0) ? exp_push.pop_front() : '1;
                chk({qm_qnum, qm_wdata} == e, "R6 push queue/pointer", int'(qm_wdata), int'(e[31:0]));
                chk({qm_qnum} == e[37:32], "R6 push target queue", qm_qnum, e[37:32]);
                qs[qm_qnum].push_back(qm_wdata);
                if (int'(qm_qnum) != RETQ || qs[qm_qnum].size() == 0 || exp_push.size() == 0) begin
                    // final push of a transfer when nothing more expected for it
                end
                if (exp_push.size() == 0 || e[37:32] != QW'(RETQ)) begin
                    tx_popped = 0;
                    last_empty = -1;
                    chk_busy_lo = 1;
                end
            end
        end
        mem_ack = mem_req && (cyc % 3 != 2);
        if (mem_ack) begin
            mem_acc_cnt++;
            if (mem_we) begin
                mem_w[mem_addr[13:2]] = mem_wdata;
                mem_wr_cnt++;
            end else mem_rdata = mem_w[mem_addr[13:2]];
        end
    end

    // Driver: builds a transmit descriptor and queues the expected pushes.
    task automatic send_pkt(input int txd, input int hint, input int flow, input int len,
                            input int src, input int rxd, input int rhint, input bit drop);
        mem_w[(txd >> 2) + 0] = 32'(len) | (32'(flow) << 16);
        mem_w[(txd >> 2) + 1] = 32'(src);
        mem_w[(txd >> 2) + 3] = 32'(RETQ);
        for (int i = 0; i < len; i++) mem_w[(src >> 2) + i] = 32'hA000_0000 + 32'(txd) + 32'(i);
        exp_fq.push_back(10 + flow);
        exp_push.push_back({QW'(RETQ), 32'(txd | hint)});
        if (!drop) exp_push.push_back({QW'(20 + flow), 32'(rxd | rhint)});
        qs[TXQ].push_back(32'(txd | hint));
    endtask

    task automatic give_rx(input int rxd, input int rhint, input int dst, input int cap, input int flow);
        mem_w[(rxd >> 2) + 0] = 32'hFFFF_FFFF;
        mem_w[(rxd >> 2) + 1] = 32'(dst);
        mem_w[(rxd >> 2) + 2] = 32'(cap);
        for (int i = 0; i <= cap; i++) mem_w[(dst >> 2) + i] = 32'h5EE0_0000 + 32'(i);
        qs[10 + flow].push_back(32'(rxd | rhint));
    endtask

    task automatic wait_done();
        int t = 0;
        while ((exp_push.size() != 0 || busy || qs[TXQ].size() != 0) && t < 3000) begin
            @(posedge clk);
            t++;
        end
        repeat (3) @(posedge clk);
        #1;
    endtask

    task automatic chk_rx(input int txd, input int rxd, input int dst, input int len, input int cap, input string tag);
        int n = (len > cap) ? cap : len;
        for (int i = 0; i < n; i++)
            chk(mem_w[(dst >> 2) + i] == 32'hA000_0000 + 32'(txd) + 32'(i), {tag, " R4 copied word"},
                int'(mem_w[(dst >> 2) + i]), int'(32'hA000_0000 + 32'(txd) + 32'(i)));
        chk(mem_w[(dst >> 2) + n] == 32'h5EE0_0000 + 32'(n), {tag, " R4 no write past count"},
            int'(mem_w[(dst >> 2) + n]), int'(32'h5EE0_0000 + 32'(n)));
        chk(mem_w[rxd >> 2] == ({len > cap, 31'd0} | 32'(n)), {tag, " R5 rx info word"},
            int'(mem_w[rxd >> 2]), int'({len > cap, 31'd0} | 32'(n)));
    endtask

    initial begin
        int s0, e0, w0;
        for (int i = 0; i < 4096; i++) mem_w[i] = '0;
        repeat (5) @(posedge clk);
        #1;
        chk(busy == 1'b0, "R1 busy in reset", busy, 0);
        chk(starve_cnt == 0, "R1 starve count in reset", starve_cnt, 0);
        chk(mem_req == 1'b0, "R1 no memory request in reset", mem_req, 0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (40) @(posedge clk);
        #1;
        chk(txpop_cnt == 0, "R2 no pop on empty tx queue", txpop_cnt, 0);
        chk(mem_acc_cnt == 0, "R2 no memory use while idle", mem_acc_cnt, 0);

        // Short packet, roomy buffer, hint bits set (R7).
        give_rx(32'h400, 3, 32'h1000, 8, 0);
        send_pkt(32'h200, 5, 0, 5, 32'h800, 32'h400, 3, 0);
        wait_done();
        chk_rx(32'h200, 32'h400, 32'h1000, 5, 8, "short R7");

        // Truncation: length 10 into capacity 4.
        give_rx(32'h440, 9, 32'h1100, 4, 2);
        send_pkt(32'h240, 1, 2, 10, 32'h900, 32'h440, 9, 0);
        wait_done();
        chk_rx(32'h240, 32'h440, 32'h1100, 10, 4, "trunc");

        // Exact fit plus a back-to-back second packet.
        give_rx(32'h480, 2, 32'h1200, 3, 1);
        give_rx(32'h4C0, 4, 32'h1300, 6, 1);
        send_pkt(32'h280, 7, 1, 3, 32'hA00, 32'h480, 2, 0);
        send_pkt(32'h2C0, 2, 1, 6, 32'hB00, 32'h4C0, 4, 0);
        wait_done();
        chk_rx(32'h280, 32'h480, 32'h1200, 3, 3, "exact");
        chk_rx(32'h2C0, 32'h4C0, 32'h1300, 6, 6, "b2b");
        chk(qs[21].size() == 2 && qs[21][0] == 32'h482, "R6 delivery order", int'(qs[21].size()), 2);

        // Drop mode: flow 1 free queue empty.
        s0 = starve_cnt; e0 = empty_pops; w0 = mem_wr_cnt;
        send_pkt(32'h300, 6, 1, 4, 32'hC00, 0, 0, 1);
        wait_done();
        chk(mem_wr_cnt == w0, "R8 no memory write on drop", mem_wr_cnt - w0, 0);
        chk(qs[RETQ][qs[RETQ].size()-1] == 32'h306, "R8 tx returned", int'(qs[RETQ][qs[RETQ].size()-1]), 32'h306);
        chk(int'(starve_cnt) - s0 == 1, "R10 one starvation on drop", int'(starve_cnt) - s0, 1);
        chk(empty_pops - e0 == 1, "R8 single empty pop", empty_pops - e0, 1);

        // Hold mode: flow 3 free queue empty, descriptor appears later.
        s0 = starve_cnt; e0 = empty_pops;
        send_pkt(32'h340, 3, 3, 4, 32'hD00, 32'h500, 1, 0);
        repeat (70) @(posedge clk);
        #1;
        chk(busy == 1'b1, "R9 held while starved", busy, 1);
        give_rx(32'h500, 1, 32'h1400, 8, 3);
        wait_done();
        chk_rx(32'h340, 32'h500, 32'h1400, 4, 8, "hold R9");
        chk(empty_pops - e0 >= 3, "R9 retries seen", empty_pops - e0, 3);
        chk(int'(starve_cnt) - s0 == empty_pops - e0, "R10 count matches empty pops",
            int'(starve_cnt) - s0, empty_pops - e0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule